// File: doc/BRIEF.md
# Dual-Channel Seven-to-One Pixel Serializer

This block turns parallel pixel words into narrow serial streams for a display link. Each pixel word is 28 bits wide. It is captured on a selectable edge of a pixel clock and sent over four data lanes, seven bits per lane, with a forwarded clock lane running beside them. Two such output links exist, A and B. A two-bit mode input chooses how the input channels reach the links. One input can feed link A alone. One input can be split so that alternate pixels go to A and B at half the per-link rate. Or two inputs can feed the two links side by side.

The whole block runs on a bit clock seven times the pixel rate. The pixel clock enters as a sampled signal, so all state sits in one clock domain. A sleep input and the reserved mode code both silence every serial output and clear the internal state. The first frame after waking is therefore always aligned to slot 0. An 18-bit colour option blanks the lane that carries the low colour bits.

Top module: `pxs_serializer`

## Requirements
- R1: While `run_en` is 0, all ten serial outputs are 0 from the next bit clock onward, and pixels offered meanwhile are never sent.
- R2: While `mode_sel` is 2'b11 (reserved), all serial outputs are 0 from the next bit clock onward, even with `run_en` at 1.
- R3: A pixel word w is sent on lane l as bits w[7l+6] down to w[7l], highest first. Slot 0 appears in the bit clock cycle right after the capture edge is sampled, so the first outputs are {w[27],w[20],w[13],w[6]} on lanes 3..0.
- R4: The clock lane of a link sends 1,1,0,0,0,1,1 over the seven slots of every frame. It starts at 1 in slot 0.
- R5: With `rise_sel` 1, words are taken on rising pixel clock edges. With `rise_sel` 0, they are taken on falling edges. Data present at the other edge is not sent.
- R6: With `mode_sel` 2'b00, every captured `pix_a` word goes out on link A, and link B stays at 0 throughout.
- R7: With `mode_sel` 2'b10, `pix_a` words go out on link A and `pix_b` words go out on link B. The frames of both links are aligned.
- R8: With `mode_sel` 2'b01, the first, third, fifth... `pix_a` words after waking go to link A, and the second, fourth... go to link B. Both links start a frame together on every second capture. Each slot is held for two bit clocks.
- R9: With `narrow_sel` 1, lane 3 of every active link stays 0. Bits 27..21 (the two low bits of each colour, plus the spare bit) are therefore not sent, and lanes 0..2 are unchanged.
- R10: After wake-up, the first complete frame on each link carries the first word (or, in the split mode, pair of words) captured after wake-up, starting at slot 0. A frame cut by sleep is never completed.
- R11: Bits 18, 19 and 20 of each word (horizontal sync, vertical sync, data enable) travel on lane 2 in both colour modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_clk | input | 1 | Pixel clock, sampled on `clk` |
| pix_a | input | 28 | Input channel A pixel word |
| pix_b | input | 28 | Input channel B pixel word |
| mode_sel | input | 2 | 00 one-in/one-out, 01 one-in/two-out, 10 two-in/two-out, 11 reserved |
| rise_sel | input | 1 | 1 captures on the rising pixel edge, 0 on the falling edge |
| run_en | input | 1 | 1 active, 0 sleep |
| narrow_sel | input | 1 | 1 selects 18-bit colour, 0 selects 24-bit |
| link_a_dat | output | 4 | Link A serial data lanes |
| link_a_clk | output | 1 | Link A forwarded clock lane |
| link_b_dat | output | 4 | Link B serial data lanes |
| link_b_clk | output | 1 | Link B forwarded clock lane |

## Verification
A model receiver in the bench locks onto each forwarded clock lane. It rebuilds words from the serial lanes and compares them with pseudo-random pixel sequences.

Each capture-edge choice is tested with junk data placed at the opposite edge, so a wrong edge shows as corrupted words. The dual-input run feeds distinct streams to A and B, which exposes crossed or misaligned channels. The split run uses an even pixel count, so that the order between links and the half-rate framing show up.

The 18-bit, reserved-mode and mid-frame sleep runs check which words are sent and which bits and frames disappear. A direct check on the first slot after the first capture pins the latency and the bit order.

// File: rtl/pxs_pkg.sv
`timescale 1ns/1ps
package pxs_pkg;

  typedef enum logic [1:0] {
    MODE_ONE_ONE = 2'b00,
    MODE_SPLIT   = 2'b01,
    MODE_TWO_TWO = 2'b10,
    MODE_RSVD    = 2'b11
  } link_mode_t;

  // Mask that keeps every lane except the top one.
  function automatic logic [63:0] low_lanes_mask(input int lanes, input int slots);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < (lanes - 1) * slots) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/pxs_edge_pick.sv
`timescale 1ns/1ps
module pxs_edge_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_clk,
  input  logic rise_sel,
  output logic edge_hit
);

  logic pix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pix_q <= 1'b0;
    else        pix_q <= pix_clk;
  end

  // The selected pixel clock transition, seen in the bit clock domain.
  assign edge_hit = rise_sel ? (pix_clk & ~pix_q) : (~pix_clk & pix_q);

endmodule

// File: rtl/pxs_router.sv
`timescale 1ns/1ps
module pxs_router
  import pxs_pkg::*;
#(
  parameter int LANES = 4,
  parameter int SLOTS = 7,
  localparam int WORD = LANES * SLOTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            quiet,
  input  logic            cap,
  input  logic [1:0]      mode_sel,
  input  logic            narrow_sel,
  input  logic [WORD-1:0] in_a,
  input  logic [WORD-1:0] in_b,
  output logic            load_a,
  output logic            load_b,
  output logic            step,
  output logic [WORD-1:0] word_a,
  output logic [WORD-1:0] word_b
);

  localparam logic [63:0]     MASK64    = low_lanes_mask(LANES, SLOTS);
  localparam logic [WORD-1:0] KEEP_MASK = MASK64[WORD-1:0];

  function automatic logic [WORD-1:0] shape(input logic [WORD-1:0] w, input logic nar);
    return nar ? (w & KEEP_MASK) : w;
  endfunction

  link_mode_t      mode;
  logic            odd_q;   // next split capture is the second of a pair
  logic            half_q;  // half-rate step phase
  logic [WORD-1:0] held_q;  // first word of a split pair
  logic            live_cap;
  logic            split;

  assign mode     = link_mode_t'(mode_sel);
  assign split    = (mode == MODE_SPLIT);
  assign live_cap = cap & ~quiet;

  always_comb begin
    load_a = 1'b0;
    load_b = 1'b0;
    word_a = shape(in_a, narrow_sel);
    word_b = shape(in_b, narrow_sel);
    unique case (mode)
      MODE_ONE_ONE: load_a = live_cap;
      MODE_TWO_TWO: begin
        load_a = live_cap;
        load_b = live_cap;
      end
      MODE_SPLIT: begin
        load_a = live_cap & odd_q;
        load_b = live_cap & odd_q;
        word_a = held_q;
        word_b = shape(in_a, narrow_sel);
      end
      default: ;
    endcase
  end

  assign step = split ? half_q : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      odd_q  <= 1'b0;
      half_q <= 1'b0;
      held_q <= '0;
    end else if (quiet) begin
      odd_q  <= 1'b0;
      half_q <= 1'b0;
      held_q <= '0;
    end else begin
      half_q <= (load_a | load_b) ? 1'b0 : ~half_q;
      if (live_cap && split) begin
        odd_q <= ~odd_q;
        if (!odd_q) held_q <= shape(in_a, narrow_sel);
      end
    end
  end

endmodule

// File: rtl/pxs_lane_bank.sv
`timescale 1ns/1ps
module pxs_lane_bank #(
  parameter int              LANES   = 4,
  parameter int              SLOTS   = 7,
  parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011,
  localparam int             WORD    = LANES * SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic             step,
  input  logic [WORD-1:0]  word,
  output logic [LANES-1:0] dat,
  output logic             fwd_clk
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] sh_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     sh_q <= '0;
      else if (clear) sh_q <= '0;
      else if (load)  sh_q <= word[l*SLOTS +: SLOTS];
      else if (step)  sh_q <= {sh_q[SLOTS-2:0], 1'b0};
    end
    assign dat[l] = sh_q[SLOTS-1];
  end

  logic [SLOTS-1:0] ck_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ck_q <= '0;
    else if (clear) ck_q <= '0;
    else if (load)  ck_q <= CLK_PAT;
    else if (step)  ck_q <= {ck_q[SLOTS-2:0], 1'b0};
  end
  assign fwd_clk = ck_q[SLOTS-1];

endmodule

// File: rtl/pxs_serializer.sv
`timescale 1ns/1ps
module pxs_serializer
  import pxs_pkg::*;
#(
  parameter int               LANES   = 4,
  parameter int               SLOTS   = 7,
  parameter logic [SLOTS-1:0] CLK_PAT = 7'b1100011,
  localparam int              WORD    = LANES * SLOTS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_clk,
  input  logic [WORD-1:0]  pix_a,
  input  logic [WORD-1:0]  pix_b,
  input  logic [1:0]       mode_sel,
  input  logic             rise_sel,
  input  logic             run_en,
  input  logic             narrow_sel,
  output logic [LANES-1:0] link_a_dat,
  output logic             link_a_clk,
  output logic [LANES-1:0] link_b_dat,
  output logic             link_b_clk
);

  logic            quiet;
  logic            cap_evt;
  logic            load_a;
  logic            load_b;
  logic            step;
  logic [WORD-1:0] word_a;
  logic [WORD-1:0] word_b;

  assign quiet = ~run_en | (link_mode_t'(mode_sel) == MODE_RSVD);

  pxs_edge_pick u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pix_clk  (pix_clk),
    .rise_sel (rise_sel),
    .edge_hit (cap_evt)
  );

  pxs_router #(.LANES(LANES), .SLOTS(SLOTS)) u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .quiet      (quiet),
    .cap        (cap_evt),
    .mode_sel   (mode_sel),
    .narrow_sel (narrow_sel),
    .in_a       (pix_a),
    .in_b       (pix_b),
    .load_a     (load_a),
    .load_b     (load_b),
    .step       (step),
    .word_a     (word_a),
    .word_b     (word_b)
  );

  pxs_lane_bank #(.LANES(LANES), .SLOTS(SLOTS), .CLK_PAT(CLK_PAT)) u_link_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (quiet),
    .load    (load_a),
    .step    (step),
    .word    (word_a),
    .dat     (link_a_dat),
    .fwd_clk (link_a_clk)
  );

  pxs_lane_bank #(.LANES(LANES), .SLOTS(SLOTS), .CLK_PAT(CLK_PAT)) u_link_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (quiet),
    .load    (load_b),
    .step    (step),
    .word    (word_b),
    .dat     (link_b_dat),
    .fwd_clk (link_b_clk)
  );

endmodule

// File: rtl/pxs_serializer_chk.sv
`timescale 1ns/1ps
module pxs_serializer_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pix_clk,
  input logic [1:0]       mode_sel,
  input logic             rise_sel,
  input logic             run_en,
  input logic             narrow_sel,
  input logic [LANES-1:0] link_a_dat,
  input logic             link_a_clk,
  input logic [LANES-1:0] link_b_dat,
  input logic             link_b_clk,
  input logic             cap_evt,
  input logic             load_a,
  input logic             load_b
);

  p_sleep_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (link_a_dat == '0 && !link_a_clk && link_b_dat == '0 && !link_b_clk));

  p_reserved_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b11) |=> (link_a_dat == '0 && !link_a_clk && link_b_dat == '0 && !link_b_clk));

  p_clock_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_a |=> link_a_clk);

  p_edge_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (rise_sel ? (pix_clk && !$past(pix_clk)) : (!pix_clk && $past(pix_clk))));

  p_single_no_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_b |-> (mode_sel != 2'b00));

  p_split_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == 2'b01 && load_a) |-> load_b);

  p_narrow_lane3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_a && narrow_sel) |=> !link_a_dat[LANES-1]);

endmodule

bind pxs_serializer pxs_serializer_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_clk    (pix_clk),
  .mode_sel   (mode_sel),
  .rise_sel   (rise_sel),
  .run_en     (run_en),
  .narrow_sel (narrow_sel),
  .link_a_dat (link_a_dat),
  .link_a_clk (link_a_clk),
  .link_b_dat (link_b_dat),
  .link_b_clk (link_b_clk),
  .cap_evt    (cap_evt),
  .load_a     (load_a),
  .load_b     (load_b)
);

// File: tb/pxs_serializer_test.sv
`timescale 1ns/1ps
module pxs_serializer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_clk = 1'b0;
  logic [27:0] pix_a = '0;
  logic [27:0] pix_b = '0;
  logic [1:0]  mode_sel = 2'b00;
  logic        rise_sel = 1'b1;
  logic        run_en = 1'b0;
  logic        narrow_sel = 1'b0;
  logic [3:0]  link_a_dat;
  logic        link_a_clk;
  logic [3:0]  link_b_dat;
  logic        link_b_clk;

  always #2.5 clk = ~clk;

  pxs_serializer uut (
    .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .pix_a(pix_a), .pix_b(pix_b),
    .mode_sel(mode_sel), .rise_sel(rise_sel), .run_en(run_en), .narrow_sel(narrow_sel),
    .link_a_dat(link_a_dat), .link_a_clk(link_a_clk),
    .link_b_dat(link_b_dat), .link_b_clk(link_b_clk)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] seed = 32'h1234_5678;

  // expected and received words per link
  logic [27:0] exp_a [0:31];
  logic [27:0] exp_b [0:31];
  logic [27:0] rx_a  [0:31];
  logic [27:0] rx_b  [0:31];
  int exp_an, exp_bn, rx_an, rx_bn, split_k;
  bit rx_half, a_high, b_high, l3_high;
  logic [13:0] hca, hcb;
  logic [13:0] hda [4];
  logic [13:0] hdb [4];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [27:0] trim(input logic [27:0] w, input bit nar);
    // 18-bit mode: nothing above bit 20 is sent
    return nar ? {7'd0, w[20:0]} : w;
  endfunction

  function automatic logic [27:0] unpack(input bit half, input bit chan_b);
    logic [27:0] w;
    for (int l = 0; l < 4; l++)
      for (int j = 0; j < 7; j++)
        w[7*l + j] = chan_b ? (half ? hdb[l][2*j+1] : hdb[l][j])
                            : (half ? hda[l][2*j+1] : hda[l][j]);
    return w;
  endfunction

  // model receiver: locks on the forwarded clock pattern
  always @(posedge clk) begin
    #1;
    hca = {hca[12:0], link_a_clk};
    hcb = {hcb[12:0], link_b_clk};
    for (int l = 0; l < 4; l++) begin
      hda[l] = {hda[l][12:0], link_a_dat[l]};
      hdb[l] = {hdb[l][12:0], link_b_dat[l]};
    end
    if (link_a_dat != 0 || link_a_clk) a_high = 1;
    if (link_b_dat != 0 || link_b_clk) b_high = 1;
    if (link_a_dat[3] || link_b_dat[3]) l3_high = 1;
    if (rx_half ? (hca == 14'b11110000001111) : (hca[6:0] == 7'b1100011)) begin
      if (rx_an < 32) rx_a[rx_an] = unpack(rx_half, 0);
      rx_an++;
    end
    if (rx_half ? (hcb == 14'b11110000001111) : (hcb[6:0] == 7'b1100011)) begin
      if (rx_bn < 32) rx_b[rx_bn] = unpack(rx_half, 1);
      rx_bn++;
    end
  end

  function automatic logic [27:0] next_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[31:4];
  endfunction

  task automatic set_cfg(input logic [1:0] m, input bit rise, input bit nar);
    @(negedge clk);
    run_en = 0;
    mode_sel = m;
    rise_sel = rise;
    narrow_sel = nar;
    pix_clk = rise ? 1'b0 : 1'b1;
    repeat (4) @(negedge clk);
    hca = '0; hcb = '0;
    for (int l = 0; l < 4; l++) begin hda[l] = '0; hdb[l] = '0; end
    rx_an = 0; rx_bn = 0; exp_an = 0; exp_bn = 0; split_k = 0;
    a_high = 0; b_high = 0; l3_high = 0;
    rx_half = (m == 2'b01);
  endtask

  task automatic wake();
    @(negedge clk);
    run_en = 1;
  endtask

  // n pixel periods; selected edge at tick 0, junk data at the other edge
  task automatic run_pixels(input int n, input bit lat_chk);
    for (int i = 0; i < n; i++) begin
      for (int t = 0; t < 7; t++) begin
        @(negedge clk);
        if (t == 0) begin
          pix_clk = rise_sel;
          pix_a = next_word();
          pix_b = next_word();
          if (run_en && mode_sel != 2'b11) begin
            if (mode_sel == 2'b01) begin
              if (split_k[0] == 0) begin exp_a[exp_an] = trim(pix_a, narrow_sel); exp_an++; end
              else begin exp_b[exp_bn] = trim(pix_a, narrow_sel); exp_bn++; end
              split_k++;
            end else begin
              exp_a[exp_an] = trim(pix_a, narrow_sel); exp_an++;
              if (mode_sel == 2'b10) begin exp_b[exp_bn] = trim(pix_b, narrow_sel); exp_bn++; end
            end
          end
          if (lat_chk && i == 0) begin
            logic [27:0] w;
            w = trim(pix_a, narrow_sel);
            @(posedge clk); #1;
            check(link_a_dat == {w[27], w[20], w[13], w[6]}, "R3", "first slot lanes",
                  {28'd0, link_a_dat}, {28'd0, w[27], w[20], w[13], w[6]});
            check(link_a_clk == 1'b1, "R4", "clock lane slot 0", {31'd0, link_a_clk}, 32'd1);
          end
        end else if (t == 4) begin
          pix_clk = ~rise_sel;
          pix_a = ~pix_a ^ 28'h5A5_A5A5;
          pix_b = ~pix_b ^ 28'h3C3_C3C3;
        end
      end
    end
  endtask

  task automatic compare(input string req, input bit chan_b);
    int en, rn;
    en = chan_b ? exp_bn : exp_an;
    rn = chan_b ? rx_bn : rx_an;
    check(rn == en, req, chan_b ? "link B word count" : "link A word count", rn, en);
    for (int i = 0; i < en && i < rn && i < 32; i++)
      if (chan_b) check(rx_b[i] == exp_b[i], req, "link B word", {4'd0, rx_b[i]}, {4'd0, exp_b[i]});
      else        check(rx_a[i] == exp_a[i], req, "link A word", {4'd0, rx_a[i]}, {4'd0, exp_a[i]});
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    check(link_a_dat == 0 && !link_a_clk && link_b_dat == 0 && !link_b_clk, "R1",
          "outputs after reset", {26'd0, link_a_clk, link_a_dat, link_b_clk}, 32'd0);
  endtask

  task automatic t_single_rise();   // R6 R3 R4 R5 R10
    set_cfg(2'b00, 1, 0);
    wake();
    run_pixels(6, 1);
    repeat (20) @(negedge clk);
    compare("R6", 0);
    check(!b_high, "R6", "link B stays low", b_high, 0);
  endtask

  task automatic t_dual_fall();     // R7 R5
    set_cfg(2'b10, 0, 0);
    wake();
    run_pixels(8, 1);
    repeat (20) @(negedge clk);
    compare("R7", 0);
    compare("R5", 1);
  endtask

  task automatic t_split();         // R8 R10
    set_cfg(2'b01, 1, 0);
    wake();
    run_pixels(8, 0);
    repeat (30) @(negedge clk);
    compare("R8", 0);
    compare("R8", 1);
  endtask

  task automatic t_narrow();        // R9 R11
    set_cfg(2'b10, 1, 1);
    wake();
    run_pixels(6, 1);
    repeat (20) @(negedge clk);
    compare("R9", 0);
    compare("R11", 1);
    check(!l3_high, "R9", "lane 3 stays low", l3_high, 0);
  endtask

  task automatic t_sleep_mid();     // R1 R10
    set_cfg(2'b00, 1, 0);
    wake();
    run_pixels(5, 0);
    run_en = 0;                     // cuts the frame of the last word
    exp_an--;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      check(link_a_dat == 0 && !link_a_clk, "R1", "link A in sleep",
            {27'd0, link_a_clk, link_a_dat}, 32'd0);
    end
    run_pixels(3, 0);               // offered while asleep, never sent
    wake();
    run_pixels(4, 0);
    repeat (20) @(negedge clk);
    compare("R10", 0);
  endtask

  task automatic t_reserved();      // R2
    set_cfg(2'b11, 1, 0);
    wake();
    run_pixels(6, 0);
    repeat (20) @(negedge clk);
    check(!a_high && !b_high, "R2", "outputs in reserved mode", {a_high, b_high}, 0);
    check(rx_an == 0 && rx_bn == 0, "R2", "frames in reserved mode", rx_an + rx_bn, 0);
  endtask

  initial begin
    for (int l = 0; l < 4; l++) begin hda[l] = '0; hdb[l] = '0; end
    hca = '0; hcb = '0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single_rise();
    t_dual_fall();
    t_split();
    t_narrow();
    t_sleep_mid();
    t_reserved();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule